// File: doc/BRIEF.md
# ADC Conversion Result Queue with Word Packer

This block sits between an ADC scan sequencer and the register side of an ADC peripheral. Each time the sequencer finishes a conversion, it presents an 8-bit channel tag and a 16-bit sample. The block packs the pair into a 32-bit word in one of six layouts. Three layouts are right-justified and sign-extended, and three are left-justified and zero-filled. The packed word goes into a 16-word first-in first-out store.

Software or a DMA agent removes words through a destructive pull or inspects the oldest word through a non-destructive peek. It watches the live occupancy and a level flag that rises once the occupancy reaches a programmable threshold. A flush empties the store over a fixed four-cycle window. During that window a busy bit is high and every arriving result is discarded.

Four sticky event flags each have an enable, a software set and a clear. They are read back both raw and masked, and the masked flags are combined into one interrupt line. The flags record:
- a stored result,
- the level reached,
- a write refused because the store is full,
- a pull from an empty store.

The flush is run by a two-state machine:
- ST_IDLE leaves on the transition "accept" when a flush request arrives while the block is enabled.
- ST_FLUSH counts down four cycles and returns on the transition "drain done", which also empties the store.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset the occupancy is 0, the busy bit, read-valid, read data, level flag, all pending flags and all enables are 0.
- R2: Layout codes 0, 1 and 2 give {tag[7:0], sign fill, sample[15:0] / [11:0] / [7:0]}. The fill copies bit 15, bit 11 or bit 7 of the sample respectively, and sample bits above the chosen width are ignored.
- R3: Layout code 3 gives {sample[15:0], 8'h00, tag}, code 4 gives {sample[11:0], 12'h000, tag}, and code 5 gives {sample[7:0], 16'h0000, tag}. Codes 6 and 7 behave as code 0.
- R4: Words leave in arrival order. A result presented with in_valid while enabled and not busy is counted in fifo_count after that clock edge. A pull puts the oldest word on rd_data with rd_valid one cycle later and lowers the count by one.
- R5: A peek puts the oldest word on rd_data with rd_valid, and the count is left unchanged. A peek on an empty store returns 0 and raises no flag.
- R6: The store holds 16 words. A write arriving while full is dropped and sets pending bit 2 (overflow).
- R7: A pull from an empty store returns 0 with rd_valid and sets pending bit 3 (underflow).
- R8: dvl_flag is high whenever fifo_count is at least dvl_sel+1, for thresholds 1 to 16. While it is high, pending bit 1 is set.
- R9: A flush request is taken only while enable is high and no flush is running. Once taken, flush_busy is high for exactly four cycles, after which fifo_count reads 0.
- R10: Results arriving while flush_busy is high or while enable is low are discarded, and pull and peek requests while busy produce no read.
- R11: Pending bits are set by events or by irq_sw_set and cleared by irq_sw_clr, with a set winning over a clear in the same cycle. Enables follow irq_en_set and irq_en_clr in the same way. irq_masked is pending AND enabled, and irq_line is the OR of irq_masked. Pending bit 0 is set by every stored result.
- R12: A write and a pull in the same cycle are both judged against the occupancy before that cycle. The pull returns the old oldest word, and the count is unchanged when both succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; gates result writes and flush requests |
| in_valid | input | 1 | Conversion result present this cycle |
| in_id | input | 8 | Channel tag of the result |
| in_data | input | 16 | Conversion sample |
| fmt_sel | input | 3 | Packing layout code (0 to 5; 6 and 7 act as 0) |
| dvl_sel | input | 4 | Level threshold minus one |
| pull | input | 1 | Destructive read strobe |
| peek | input | 1 | Non-destructive read strobe |
| rd_data | output | 32 | Word returned by the last pull or peek |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| fifo_count | output | 5 | Current occupancy |
| dvl_flag | output | 1 | Occupancy has reached the threshold |
| flush_req | input | 1 | Flush request strobe |
| flush_busy | output | 1 | Flush in progress |
| irq_en_set | input | 4 | Enable-set strobes per flag |
| irq_en_clr | input | 4 | Enable-clear strobes per flag |
| irq_sw_set | input | 4 | Software set of pending flags |
| irq_sw_clr | input | 4 | Clear of pending flags |
| irq_pending | output | 4 | Raw pending flags (0 stored, 1 level, 2 overflow, 3 underflow) |
| irq_masked | output | 4 | Pending and enabled flags |
| irq_line | output | 1 | OR of the masked flags |

## Verification
The delicate collision is a result write and a pull in the same cycle. Both are judged against the occupancy before the edge, so one can succeed while the other is refused. The bench provokes it at a partly filled store and at a completely full one. In the full case the write is dropped with an overflow flag and the pull still drains a word. The scoreboard model replays each collision by taking the pull from its queue before it considers the push. It then compares the returned word, the occupancy and the overflow flag against that ordering.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
    localparam int WORD_W  = 32;
    localparam int ID_W    = 8;
    localparam int DATA_W  = 16;
    localparam int FMT_W   = 3;
    localparam int NUM_IRQ = 4;

    localparam int IRQ_STORED = 0;
    localparam int IRQ_LEVEL  = 1;
    localparam int IRQ_OVF    = 2;
    localparam int IRQ_UDF    = 3;

    typedef enum logic [FMT_W-1:0] {
        FMT_R16 = 3'd0,
        FMT_R12 = 3'd1,
        FMT_R8  = 3'd2,
        FMT_L16 = 3'd3,
        FMT_L12 = 3'd4,
        FMT_L8  = 3'd5
    } fmt_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FLUSH = 1'b1
    } flush_state_e;
endpackage

// File: rtl/adcf_pack.sv
module adcf_pack
    import adcf_pkg::*;
(
    input  logic [FMT_W-1:0]  fmt_sel,
    input  logic [ID_W-1:0]   tag,
    input  logic [DATA_W-1:0] sample,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        unique case (fmt_sel)
            FMT_R12: word = {tag, {12{sample[11]}}, sample[11:0]};
            FMT_R8:  word = {tag, {16{sample[7]}}, sample[7:0]};
            FMT_L16: word = {sample[15:0], 8'h00, tag};
            FMT_L12: word = {sample[11:0], 12'h000, tag};
            FMT_L8:  word = {sample[7:0], 16'h0000, tag};
            default: word = {tag, {8{sample[15]}}, sample[15:0]};
        endcase
    end
endmodule

// File: rtl/adcf_flush_ctrl.sv
module adcf_flush_ctrl
    import adcf_pkg::*;
#(
    parameter int FLUSH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic flush_req,
    output logic busy,
    output logic drain_done
);
    localparam int CNT_W = (FLUSH_CYC > 2) ? $clog2(FLUSH_CYC) : 1;

    flush_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush_req && enable) begin
                    state_d = ST_FLUSH;
                    cnt_d   = CNT_W'(FLUSH_CYC - 1);
                end
            end
            ST_FLUSH: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state_q == ST_FLUSH);
        drain_done = (state_q == ST_FLUSH) && (cnt_q == '0);
    end
endmodule

// File: rtl/adcf_store.sv
module adcf_store #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_req,
    input  logic [W-1:0]                 wdata,
    input  logic                         pull_req,
    input  logic                         peek_req,
    input  logic                         clear,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [W-1:0]                 rd_data,
    output logic                         rd_valid,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pull_ok, read_any;

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign push_ok  = push_req && !full;
    assign pull_ok  = pull_req && !empty;
    assign read_any = pull_req || peek_req;
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + 1'b1;
            if (pull_ok) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pull_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= read_any;
            if (read_any) rd_data <= empty ? '0 : mem[rp_q];
        end
    end
endmodule

// File: rtl/adcf_irq.sv
module adcf_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_evt,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] pending,
    output logic [N-1:0] masked,
    output logic         line
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
            en_q    <= '0;
        end else begin
            pending <= (pending & ~sw_clr) | sw_set | hw_evt;
            en_q    <= (en_q & ~en_clr) | en_set;
        end
    end

    assign masked = pending & en_q;
    assign line   = |masked;
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
    import adcf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int FLUSH_CYC = 4,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int TW       = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 in_valid,
    input  logic [ID_W-1:0]      in_id,
    input  logic [DATA_W-1:0]    in_data,
    input  logic [FMT_W-1:0]     fmt_sel,
    input  logic [TW-1:0]        dvl_sel,
    input  logic                 pull,
    input  logic                 peek,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [CW-1:0]        fifo_count,
    output logic                 dvl_flag,
    input  logic                 flush_req,
    output logic                 flush_busy,
    input  logic [NUM_IRQ-1:0]   irq_en_set,
    input  logic [NUM_IRQ-1:0]   irq_en_clr,
    input  logic [NUM_IRQ-1:0]   irq_sw_set,
    input  logic [NUM_IRQ-1:0]   irq_sw_clr,
    output logic [NUM_IRQ-1:0]   irq_pending,
    output logic [NUM_IRQ-1:0]   irq_masked,
    output logic                 irq_line
);
    logic [WORD_W-1:0]  packed_word;
    logic               drain_done, push_req, pull_req, peek_req;
    logic               st_full, st_empty;
    logic [CW-1:0]      level_thr;
    logic [NUM_IRQ-1:0] evt;

    adcf_pack u_pack (
        .fmt_sel (fmt_sel),
        .tag     (in_id),
        .sample  (in_data),
        .word    (packed_word)
    );

    adcf_flush_ctrl #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .flush_req  (flush_req),
        .busy       (flush_busy),
        .drain_done (drain_done)
    );

    assign push_req = in_valid && enable && !flush_busy;
    assign pull_req = pull && !flush_busy;
    assign peek_req = peek && !pull && !flush_busy;

    adcf_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .wdata    (packed_word),
        .pull_req (pull_req),
        .peek_req (peek_req),
        .clear    (drain_done),
        .count    (fifo_count),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .full     (st_full),
        .empty    (st_empty)
    );

    assign level_thr = CW'(dvl_sel) + 1'b1;
    assign dvl_flag  = (fifo_count >= level_thr);

    always_comb begin
        evt             = '0;
        evt[IRQ_STORED] = push_req && !st_full;
        evt[IRQ_LEVEL]  = dvl_flag;
        evt[IRQ_OVF]    = push_req && st_full;
        evt[IRQ_UDF]    = pull_req && st_empty;
    end

    adcf_irq #(.N(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_evt  (evt),
        .en_set  (irq_en_set),
        .en_clr  (irq_en_clr),
        .sw_set  (irq_sw_set),
        .sw_clr  (irq_sw_clr),
        .pending (irq_pending),
        .masked  (irq_masked),
        .line    (irq_line)
    );
endmodule

// File: rtl/adc_result_fifo_chk.sv
module adc_result_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          in_valid,
    input logic          pull,
    input logic          peek,
    input logic          flush_req,
    input logic          flush_busy,
    input logic [CW-1:0] fifo_count,
    input logic          dvl_flag,
    input logic [31:0]   rd_data,
    input logic [3:0]    irq_pending
);
    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R6
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == CW'(DEPTH) && in_valid && enable && !flush_busy) |=> irq_pending[2]);

    // R7
    underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0 && pull && !flush_busy) |=> (irq_pending[3] && rd_data == 32'h0));

    // R5
    peek_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (peek && !pull && !in_valid && !flush_busy && !flush_req) |=> $stable(fifo_count));

    // R8
    level_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dvl_flag |=> irq_pending[1]);

    // R9
    flush_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_busy) |-> ($past(enable) && $past(flush_req)));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> (fifo_count == '0));

    // R10
    busy_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> (fifo_count <= $past(fifo_count)));
endmodule

bind adc_result_fifo adc_result_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .in_valid    (in_valid),
    .pull        (pull),
    .peek        (peek),
    .flush_req   (flush_req),
    .flush_busy  (flush_busy),
    .fifo_count  (fifo_count),
    .dvl_flag    (dvl_flag),
    .rd_data     (rd_data),
    .irq_pending (irq_pending)
);

// File: tb/adc_result_fifo_tb_top.sv
module adc_result_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, in_valid = 1'b0, pull = 1'b0, peek = 1'b0, flush_req = 1'b0;
    logic [7:0]  in_id = '0;
    logic [15:0] in_data = '0;
    logic [2:0]  fmt_sel = '0;
    logic [3:0]  dvl_sel = 4'd3;
    logic [3:0]  en_set = '0, en_clr = '0, sw_set = '0, sw_clr = '0;
    logic [31:0] rd_data;
    logic        rd_valid, dvl_flag, flush_busy, irq_line;
    logic [4:0]  fifo_count;
    logic [3:0]  irq_pending, irq_masked;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] mdl[$];
    string       mdl_tag[$];
    logic [31:0] rd_exp[$];
    string       rd_tag[$];

    always #5 clk = ~clk;

    adc_result_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
        .in_id(in_id), .in_data(in_data), .fmt_sel(fmt_sel), .dvl_sel(dvl_sel),
        .pull(pull), .peek(peek), .rd_data(rd_data), .rd_valid(rd_valid),
        .fifo_count(fifo_count), .dvl_flag(dvl_flag), .flush_req(flush_req),
        .flush_busy(flush_busy), .irq_en_set(en_set), .irq_en_clr(en_clr),
        .irq_sw_set(sw_set), .irq_sw_clr(sw_clr), .irq_pending(irq_pending),
        .irq_masked(irq_masked), .irq_line(irq_line)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_ref(input logic [2:0] f, input logic [7:0] t, input logic [15:0] d);
        case (f)
            3'd1: pack_ref = {t, {12{d[11]}}, d[11:0]};
            3'd2: pack_ref = {t, {16{d[7]}}, d[7:0]};
            3'd3: pack_ref = {d, 8'h00, t};
            3'd4: pack_ref = {d[11:0], 12'h000, t};
            3'd5: pack_ref = {d[7:0], 16'h0000, t};
            default: pack_ref = {t, {8{d[15]}}, d};
        endcase
    endfunction

    // Driver: predicts reads (pull before push) and queues expected items.
    task automatic drive(input bit do_push, input logic [7:0] t, input logic [15:0] d,
                         input logic [2:0] f, input string rq, input bit do_pull, input bit do_peek);
        int pre = mdl.size();
        if (do_pull) begin
            if (pre > 0) begin
                rd_exp.push_back(mdl.pop_front());
                rd_tag.push_back(mdl_tag.pop_front());
            end else begin
                rd_exp.push_back(32'h0);
                rd_tag.push_back("R7");
            end
        end else if (do_peek) begin
            rd_exp.push_back(pre > 0 ? mdl[0] : 32'h0);
            rd_tag.push_back("R5");
        end
        if (do_push && enable && pre < 16) begin
            mdl.push_back(pack_ref(f, t, d));
            mdl_tag.push_back(rq);
        end
        in_valid = do_push; in_id = t; in_data = d; fmt_sel = f;
        pull = do_pull; peek = do_peek;
        @(negedge clk);
        in_valid = 1'b0; pull = 1'b0; peek = 1'b0;
    endtask

    task automatic count_chk(input string rq);
        check(fifo_count == 5'(mdl.size()), rq, 32'(fifo_count), 32'(mdl.size()));
    endtask

    // Monitor: pops expected reads and compares as results appear.
    always @(posedge clk) begin
        #2;
        if (rst_n && rd_valid) begin
            if (rd_exp.size() == 0) begin
                check(1'b0, "R4 unexpected read", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                string tg;
                e  = rd_exp.pop_front();
                tg = rd_tag.pop_front();
                check(rd_data == e, tg, rd_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fifo_count == 0 && !flush_busy && !rd_valid && rd_data == 0 && !dvl_flag,
              "R1", {fifo_count, flush_busy, rd_valid, dvl_flag}, 32'h0);
        check(irq_pending == 0 && irq_masked == 0 && !irq_line, "R1", {irq_pending, irq_masked}, 32'h0);

        enable = 1'b1;
        drive(1, 8'h12, 16'h8001, 3'd0, "R2", 0, 0);
        drive(1, 8'h34, 16'h0800, 3'd1, "R2", 0, 0);
        drive(1, 8'h35, 16'hF7FF, 3'd1, "R2", 0, 0);
        // R8 threshold 4 not yet reached
        check(!dvl_flag, "R8", {31'h0, dvl_flag}, 32'h0);
        drive(1, 8'h56, 16'h0080, 3'd2, "R2", 0, 0);
        check(dvl_flag, "R8", {31'h0, dvl_flag}, 32'h1);
        drive(1, 8'h9A, 16'hBEEF, 3'd3, "R3", 0, 0);
        drive(1, 8'h11, 16'h0ABC, 3'd4, "R3", 0, 0);
        drive(1, 8'h22, 16'h00C3, 3'd5, "R3", 0, 0);
        drive(1, 8'h01, 16'h7FFF, 3'd7, "R3", 0, 0);
        count_chk("R4");
        check(irq_pending[1] && irq_pending[0], "R8", {28'h0, irq_pending}, 32'h3);
        // R5 peek
        drive(0, 0, 0, 0, "", 0, 1);
        @(negedge clk);
        count_chk("R5");
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 0, "", 1, 0);
        @(negedge clk);
        count_chk("R4");
        // R7 underflow
        drive(0, 0, 0, 0, "", 1, 0);
        check(irq_pending[3], "R7", {28'h0, irq_pending}, 32'h8);
        // R5 peek on empty
        sw_clr = 4'hF; @(negedge clk); sw_clr = 4'h0;
        drive(0, 0, 0, 0, "", 0, 1);
        check(!irq_pending[3], "R5", {28'h0, irq_pending}, 32'h0);

        // R6 fill and overflow
        for (int i = 0; i < 16; i++) drive(1, 8'(i), 16'(i * 37), 3'd0, "R6", 0, 0);
        count_chk("R6");
        check(!irq_pending[2], "R6", {28'h0, irq_pending}, 32'h0);
        drive(1, 8'hEE, 16'h1234, 3'd0, "R6", 0, 0);
        count_chk("R6");
        check(irq_pending[2], "R6", {28'h0, irq_pending}, 32'h4);
        // R12 push+pull while full: push refused, pull succeeds
        drive(1, 8'hEF, 16'h4321, 3'd0, "R12", 1, 0);
        count_chk("R12");
        // R12 push+pull below full
        drive(1, 8'hF0, 16'h5555, 3'd3, "R12", 1, 0);
        count_chk("R12");

        // R9 flush ignored when disabled
        enable = 1'b0;
        flush_req = 1'b1; @(negedge clk); flush_req = 1'b0;
        check(!flush_busy, "R9", {31'h0, flush_busy}, 32'h0);
        count_chk("R9");
        enable = 1'b1;
        flush_req = 1'b1; @(negedge clk); flush_req = 1'b0;
        check(flush_busy, "R9", {31'h0, flush_busy}, 32'h1);
        in_valid = 1'b1; in_id = 8'hAB; pull = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; pull = 1'b0;
        check(flush_busy && !rd_valid, "R10", {30'h0, flush_busy, rd_valid}, 32'h2);
        @(negedge clk);
        check(flush_busy, "R9", {31'h0, flush_busy}, 32'h1);
        @(negedge clk);
        check(flush_busy, "R9", {31'h0, flush_busy}, 32'h1);
        @(negedge clk);
        check(!flush_busy && fifo_count == 0, "R9", {26'h0, flush_busy, fifo_count}, 32'h0);
        mdl.delete(); mdl_tag.delete();

        // R10 disabled input dropped
        enable = 1'b0;
        drive(1, 8'h77, 16'h0001, 3'd0, "R10", 0, 0);
        check(fifo_count == 0, "R10", 32'(fifo_count), 32'h0);
        enable = 1'b1;

        // R11 interrupt flags
        sw_clr = 4'hF; @(negedge clk); sw_clr = 4'h0;
        check(irq_pending == 0 && !irq_line, "R11", {28'h0, irq_pending}, 32'h0);
        en_set = 4'h1; @(negedge clk); en_set = 4'h0;
        drive(1, 8'h42, 16'h0042, 3'd0, "R11", 0, 0);
        check(irq_masked == 4'h1 && irq_line, "R11", {28'h0, irq_masked}, 32'h1);
        sw_set = 4'h2; @(negedge clk); sw_set = 4'h0;
        check(irq_pending == 4'h3 && irq_masked == 4'h1, "R11", {irq_pending, irq_masked}, 32'h31);
        en_clr = 4'h1; @(negedge clk); en_clr = 4'h0;
        check(!irq_line && irq_pending == 4'h3, "R11", {27'h0, irq_line, irq_pending}, 32'h3);
        sw_clr = 4'h2; sw_set = 4'h2; @(negedge clk); sw_clr = 4'h0; sw_set = 4'h0;
        check(irq_pending[1], "R11", {28'h0, irq_pending}, 32'h3);
        drive(0, 0, 0, 0, "", 1, 0);
        repeat (2) @(negedge clk);
        check(rd_exp.size() == 0, "R4", 32'(rd_exp.size()), 32'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule